// File: doc/BRIEF.md
# Metaframe CRC-32 Inserter

This block sits between a metaframe builder and a scrambler on an Interlaken-style lane. Words arrive one per handshake as a 64-bit data field, a 2-bit framing header, a word-kind tag and a start-of-metaframe flag. The block runs a CRC-32 over every word of each metaframe and writes the complemented result into the low 32 bits of the diagnostic word that closes the metaframe. The checksum is taken on unscrambled data. The framing header never enters the checksum.

The CRC advances over one full 64-bit word per accepted word. The register is seeded at every word flagged as a metaframe start, so metaframes may follow each other with no gap. Two fields are read as zero while they pass through the checksum: the scrambler-state contents, which change at every scrambler step, and the diagnostic word's own CRC field. All other words leave the block untouched, one register stage after they enter.

Both stream edges use valid/ready. A word is transferred on a rising edge where valid and ready are both high. The block asserts `in_ready` whenever its output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output word is held unchanged. An input cycle with no transfer changes no state.

Top module: `crc_meta_ins`

## Requirements
- R1: The CRC uses polynomial 0x1EDC6F41, non-reflected, and takes the 64 data bits most significant bit first. The register is seeded to 0xFFFFFFFF at a word with `in_sof`=1, and the value written out is the bitwise complement of the register.
- R2: The checksum covers every word of a metaframe, from the start word through the diagnostic word, including the synchronization, scrambler-state and skip words.
- R3: A diagnostic word (kind 4) leaves with bits 31:0 replaced by the CRC, while bits 63:32, the header, the kind and the start flag pass unchanged. Its incoming bits 31:0 are counted as zero and have no effect on the result.
- R4: For a scrambler-state word (kind 2), data bits 57:0 are counted as zero in the CRC and are passed to the output unchanged.
- R5: Words of kinds 0 (payload), 1 (synchronization), 2 (scrambler state) and 3 (skip) leave with data, header, kind and start flag unchanged and in order. Each word appears at the output one clock after it is accepted.
- R6: The 2-bit framing header has no effect on the CRC.
- R7: While `out_valid`=1 and `out_ready`=0, the output holds valid and keeps the same word.
- R8: `in_ready` equals `!out_valid || out_ready`. A cycle without an input transfer advances neither the CRC state nor the stream, whatever lies on the input data pins.
- R9: During reset and on the first cycle after it, `out_valid`=0 and `in_ready`=1.
- R10: Metaframes may follow one another with no idle cycle between them, and each one is checked against its own seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take a word |
| in_hdr | input | 2 | Framing header of the input word |
| in_kind | input | 3 | Word kind: 0 payload, 1 sync, 2 scrambler state, 3 skip, 4 diagnostic |
| in_sof | input | 1 | First word of a metaframe |
| in_data | input | 64 | Input data word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream can take a word |
| out_hdr | output | 2 | Framing header, passed through |
| out_kind | output | 3 | Word kind, passed through |
| out_sof | output | 1 | Metaframe start flag, passed through |
| out_data | output | 64 | Data word, with the CRC inserted into diagnostic words |

## Verification
Some properties are checked on every clock: the output is held stable under back-pressure, the CRC state stays frozen on cycles with no input transfer, non-diagnostic words are passed through exactly one cycle after acceptance, the upper half of each diagnostic word is preserved, and the output is empty just after reset. Only the bench scenarios can show that the inserted values are correct. For that, a bit-serial reference model covers random frame lengths, headers and flow control. Directed pairs of metaframes that differ only in scrambler-state contents, diagnostic low bits or headers must yield the same CRC.

// File: rtl/crc_ins_pkg.sv
package crc_ins_pkg;
  typedef enum logic [2:0] {
    WK_PAYLOAD = 3'd0,
    WK_SYNC    = 3'd1,
    WK_SCRAM   = 3'd2,
    WK_SKIP    = 3'd3,
    WK_DIAG    = 3'd4
  } word_kind_e;

  localparam int KIND_W = 3;
endpackage

// File: rtl/crc_word_mask.sv
// Zeroes the fields that must not influence the checksum.
module crc_word_mask #(
  parameter int DATA_W = 64,
  parameter int CRC_W  = 32,
  parameter int SCR_W  = 58
) (
  input  logic [DATA_W-1:0]               data_i,
  input  logic [crc_ins_pkg::KIND_W-1:0]  kind_i,
  output logic [DATA_W-1:0]               data_o
);
  import crc_ins_pkg::*;

  localparam logic [DATA_W-1:0] SCR_KEEP  = {DATA_W{1'b1}} << SCR_W;
  localparam logic [DATA_W-1:0] DIAG_KEEP = {DATA_W{1'b1}} << CRC_W;

  always_comb begin
    unique case (word_kind_e'(kind_i))
      WK_SCRAM: data_o = data_i & SCR_KEEP;
      WK_DIAG:  data_o = data_i & DIAG_KEEP;
      default:  data_o = data_i;
    endcase
  end
endmodule

// File: rtl/crc_par_step.sv
// One full data word folded into the CRC in a single cycle, MSB first.
module crc_par_step #(
  parameter int                 DATA_W = 64,
  parameter int                 CRC_W  = 32,
  parameter logic [CRC_W-1:0]   POLY   = 32'h1EDC6F41
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] acc;
  logic             fb;

  always_comb begin
    acc = crc_i;
    fb  = 1'b0;
    for (int b = DATA_W - 1; b >= 0; b--) begin
      fb  = acc[CRC_W-1] ^ data_i[b];
      acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    crc_o = acc;
  end
endmodule

// File: rtl/crc_ins_pipe.sv
// Single-entry output register with pass-through ready.
module crc_ins_pipe #(
  parameter int W = 70
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_word,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_word
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_word  <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) dn_word <= up_word;
    end
  end
endmodule

// File: rtl/crc_meta_ins.sv
module crc_meta_ins #(
  parameter int               DATA_W  = 64,
  parameter int               HDR_W   = 2,
  parameter int               CRC_W   = 32,
  parameter int               SCR_W   = 58,
  parameter logic [CRC_W-1:0] POLY    = 32'h1EDC6F41,
  parameter logic [CRC_W-1:0] SEED    = 32'hFFFFFFFF,
  parameter logic [CRC_W-1:0] XOR_OUT = 32'hFFFFFFFF
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  output logic                            in_ready,
  input  logic [HDR_W-1:0]                in_hdr,
  input  logic [crc_ins_pkg::KIND_W-1:0]  in_kind,
  input  logic                            in_sof,
  input  logic [DATA_W-1:0]               in_data,
  output logic                            out_valid,
  input  logic                            out_ready,
  output logic [HDR_W-1:0]                out_hdr,
  output logic [crc_ins_pkg::KIND_W-1:0]  out_kind,
  output logic                            out_sof,
  output logic [DATA_W-1:0]               out_data
);
  import crc_ins_pkg::*;

  localparam int WORD_W = HDR_W + KIND_W + 1 + DATA_W;

  logic              fire;
  logic [CRC_W-1:0]  crc_q;
  logic [CRC_W-1:0]  crc_base;
  logic [CRC_W-1:0]  crc_nxt;
  logic [DATA_W-1:0] masked;
  logic [DATA_W-1:0] ins_data;
  logic [WORD_W-1:0] stage_in;
  logic [WORD_W-1:0] stage_out;

  assign fire     = in_valid && in_ready;
  assign crc_base = in_sof ? SEED : crc_q;

  crc_word_mask #(.DATA_W(DATA_W), .CRC_W(CRC_W), .SCR_W(SCR_W)) u_mask (
    .data_i (in_data),
    .kind_i (in_kind),
    .data_o (masked)
  );

  crc_par_step #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) u_step (
    .crc_i  (crc_base),
    .data_i (masked),
    .crc_o  (crc_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    crc_q <= SEED;
    else if (fire) crc_q <= crc_nxt;
  end

  always_comb begin
    if (word_kind_e'(in_kind) == WK_DIAG)
      ins_data = {in_data[DATA_W-1:CRC_W], crc_nxt ^ XOR_OUT};
    else
      ins_data = in_data;
  end

  assign stage_in = {in_hdr, in_kind, in_sof, ins_data};

  crc_ins_pipe #(.W(WORD_W)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_word  (stage_in),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_word  (stage_out)
  );

  assign {out_hdr, out_kind, out_sof, out_data} = stage_out;
endmodule

// File: rtl/crc_meta_ins_chk.sv
module crc_meta_ins_chk #(
  parameter int DATA_W = 64,
  parameter int HDR_W  = 2,
  parameter int CRC_W  = 32
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            in_valid,
  input logic                            in_ready,
  input logic [HDR_W-1:0]                in_hdr,
  input logic [crc_ins_pkg::KIND_W-1:0]  in_kind,
  input logic                            in_sof,
  input logic [DATA_W-1:0]               in_data,
  input logic                            out_valid,
  input logic                            out_ready,
  input logic [HDR_W-1:0]                out_hdr,
  input logic [crc_ins_pkg::KIND_W-1:0]  out_kind,
  input logic                            out_sof,
  input logic [DATA_W-1:0]               out_data,
  input logic [CRC_W-1:0]                crc_q
);
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
      $stable(out_hdr) && $stable(out_kind) && $stable(out_sof)));

  a_r8_crc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(crc_q));

  a_r5_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_kind != 3'd4) |=>
      (out_valid && out_data == $past(in_data) && out_hdr == $past(in_hdr) &&
       out_kind == $past(in_kind) && out_sof == $past(in_sof)));

  a_r3_diag_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_kind == 3'd4) |=>
      (out_valid && out_kind == 3'd4 &&
       out_data[DATA_W-1:CRC_W] == $past(in_data[DATA_W-1:CRC_W]) &&
       out_hdr == $past(in_hdr)));

  a_r9_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && in_ready));
endmodule

bind crc_meta_ins crc_meta_ins_chk #(.DATA_W(DATA_W), .HDR_W(HDR_W), .CRC_W(CRC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_hdr(in_hdr), .in_kind(in_kind), .in_sof(in_sof), .in_data(in_data),
  .out_valid(out_valid), .out_ready(out_ready), .out_hdr(out_hdr),
  .out_kind(out_kind), .out_sof(out_sof), .out_data(out_data), .crc_q(crc_q)
);

// File: tb/sim_crc_meta_ins.sv
module sim_crc_meta_ins;
  localparam int CLK_PERIOD = 10;
  localparam int MAXW       = 1024;
  localparam int WDOG       = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        in_valid, in_ready, in_sof, out_valid, out_ready, out_sof;
  logic [1:0]  in_hdr, out_hdr;
  logic [2:0]  in_kind, out_kind;
  logic [63:0] in_data, out_data;

  crc_meta_ins u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_hdr(in_hdr), .in_kind(in_kind), .in_sof(in_sof), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_hdr(out_hdr),
    .out_kind(out_kind), .out_sof(out_sof), .out_data(out_data)
  );

  int n_tests = 0;
  int n_fail  = 0;

  logic [1:0]  st_hdr  [MAXW];
  logic [63:0] st_data [MAXW];
  logic [63:0] ex_data [MAXW];
  logic [2:0]  st_kind [MAXW];
  logic        st_sof  [MAXW];
  logic [31:0] seen_lo [MAXW];
  int          diag_at [128];
  int          nst   = 0;
  int          ndiag = 0;
  logic [31:0] run_crc = 32'hFFFFFFFF;

  // Bit-serial reference, R1: poly 0x1EDC6F41, MSB first.
  function automatic logic [31:0] ser_crc(input logic [31:0] c, input logic [63:0] d);
    for (int b = 63; b >= 0; b--) begin
      logic fb;
      fb = c[31] ^ d[b];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h1EDC6F41;
    end
    return c;
  endfunction

  // R3 / R4 masking as stated in the requirements.
  function automatic logic [63:0] mask_word(input logic [63:0] d, input logic [2:0] k);
    if (k == 3'd2) d[57:0] = '0;
    if (k == 3'd4) d[31:0] = '0;
    return d;
  endfunction

  task automatic add_word(input logic [1:0] h, input logic [63:0] d,
                          input logic [2:0] k, input logic s);
    run_crc = ser_crc(s ? 32'hFFFFFFFF : run_crc, mask_word(d, k));
    st_hdr[nst] = h; st_data[nst] = d; st_kind[nst] = k; st_sof[nst] = s;
    ex_data[nst] = (k == 3'd4) ? {d[63:32], ~run_crc} : d;
    if (k == 3'd4) begin diag_at[ndiag] = nst; ndiag++; end
    nst++;
  endtask

  task automatic add_frame(input int npay, input int nskip, input logic [57:0] scr,
                           input logic [31:0] salt, input logic [31:0] dlo,
                           input logic [1:0] hb);
    add_word(2'b10 ^ hb, 64'h78F6_78F6_78F6_78F6, 3'd1, 1'b1);
    add_word(2'b10 ^ hb, {6'h0A, scr}, 3'd2, 1'b0);
    for (int i = 0; i < nskip; i++)
      add_word(2'b10 ^ hb, 64'h1E1E_1E1E_1E1E_1E1E, 3'd3, 1'b0);
    for (int i = 0; i < npay; i++)
      add_word(2'b01 ^ hb, (salt == 0) ? 64'h0 :
               {salt * (i + 1), salt ^ (i * 32'h0100_0193)}, 3'd0, 1'b0);
    add_word(2'b10 ^ hb, {32'h6400_0003, dlo}, 3'd4, 1'b0);
  endtask

  task automatic fail_line(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_fail++;
    $display("FAIL %s actual=%h expected=%h", req, act, exp);
  endtask

  initial begin
    int idx, oidx, cyc, pace;
    logic fire_in, pv, pr;
    logic [63:0] pd;
    logic [63:0] junk;
    void'($urandom(32'h1234_5EED));

    // Directed metaframes
    add_frame(0, 0, 58'h1, 32'h0, 32'h0, 2'b00);                          // minimal
    add_frame(4, 1, 58'h2AA, 32'h0, 32'hFFFF_FFFF, 2'b00);                 // zero payload
    add_frame(3, 2, 58'h0_0001_2345_6789, 32'hABCD, 32'h0, 2'b00);
    add_frame(3, 2, 58'h3FF_FFFF_FFFF_FFFF, 32'hABCD, 32'h5A5A_5A5A, 2'b00);
    add_frame(0, 0, 58'h1, 32'h0, 32'h0, 2'b11);
    pace = nst;
    // Random metaframes
    for (int f = 0; f < 40; f++) begin
      junk = {$urandom, $urandom};
      add_frame(int'($urandom % 10), int'($urandom % 3), junk[57:0],
                $urandom | 32'h1, $urandom, 2'($urandom % 4));
    end

    in_valid = 0; out_ready = 0; in_hdr = 0; in_kind = 0; in_sof = 0; in_data = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    n_tests++; // R9: output empty during reset
    if (out_valid !== 1'b0) fail_line("R9 out_valid in reset", 64'(out_valid), 64'h0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    n_tests++; // R9: first cycle after reset
    if (out_valid !== 1'b0 || in_ready !== 1'b1)
      fail_line("R9 after reset", {62'h0, out_valid, in_ready}, 64'h1);

    idx = 0; oidx = 0; cyc = 0; pv = 0; pr = 0; pd = '0;
    while (oidx < nst && cyc < WDOG) begin
      @(negedge clk);
      cyc++;
      n_tests++; // R8 ready rule
      if (in_ready !== (!out_valid || out_ready))
        fail_line("R8 in_ready", 64'(in_ready), 64'(!out_valid || out_ready));
      if (pv && !pr) begin
        n_tests++; // R7 hold under back-pressure
        if (out_valid !== 1'b1 || out_data !== pd) fail_line("R7 hold", out_data, pd);
      end
      fire_in = in_valid && in_ready;
      if (out_valid && out_ready) begin
        n_tests++;
        if (st_kind[oidx] == 3'd4) begin
          // R1 R2 R3 R6 R10: inserted CRC against the serial reference
          seen_lo[oidx] = out_data[31:0];
          if (out_data !== ex_data[oidx]) fail_line("R1/R2/R3 diag word", out_data, ex_data[oidx]);
        end else begin
          // R4 R5: unchanged pass-through in order
          if (out_data !== ex_data[oidx]) fail_line("R5 data", out_data, ex_data[oidx]);
        end
        n_tests++;
        if (out_hdr !== st_hdr[oidx] || out_kind !== st_kind[oidx] || out_sof !== st_sof[oidx])
          fail_line("R5 side fields", {58'h0, out_hdr, out_kind, out_sof},
                    {58'h0, st_hdr[oidx], st_kind[oidx], st_sof[oidx]});
        oidx++;
      end
      pv = out_valid; pr = out_ready; pd = out_data;
      @(posedge clk); #1;
      if (fire_in) idx++;
      // R10: first directed frames run back to back at full rate
      if (idx < pace) begin
        out_ready = 1'b1;
      end else if (oidx >= 100 && (cyc % 32) < 10) begin
        out_ready = 1'b0; // R7 long stall window
      end else begin
        out_ready = ($urandom % 100) < 65;
      end
      if (idx < nst && (idx < pace || ($urandom % 100) < 70)) begin
        in_valid = 1'b1;
        in_hdr = st_hdr[idx]; in_kind = st_kind[idx];
        in_sof = st_sof[idx]; in_data = st_data[idx];
      end else begin
        // R8: junk on idle inputs must change nothing
        in_valid = 1'b0;
        in_hdr = 2'($urandom); in_kind = 3'($urandom % 5);
        in_sof = 1'($urandom); in_data = {$urandom, $urandom};
      end
    end

    if (cyc >= WDOG) fail_line("watchdog", 64'(oidx), 64'(nst));

    // R4 and R3: scrambler contents and diag low bits do not alter the CRC
    n_tests++;
    if (seen_lo[diag_at[2]] !== seen_lo[diag_at[3]])
      fail_line("R4 scrambler mask", 64'(seen_lo[diag_at[3]]), 64'(seen_lo[diag_at[2]]));
    // R6: header does not alter the CRC
    n_tests++;
    if (seen_lo[diag_at[0]] !== seen_lo[diag_at[4]])
      fail_line("R6 header ignored", 64'(seen_lo[diag_at[4]]), 64'(seen_lo[diag_at[0]]));

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule